// File: doc/BRIEF.md
# Post-Modify Address Generator

This block forms the address of one load or store and, in the same step, the new value of the base register that the access updates. It covers post-increment by a signed immediate, post-increment by a modifier register, bit-reversed addressing, circular-buffer post-increment (by immediate or by an increment field of the modifier scaled by the access size) and absolute-set addressing, where an extended immediate both addresses memory and is copied into a second destination register.

The caller presents the base, modifier, circular start and already-extended immediate together with a mode code and a size code, and pulses `valid_in`. The outputs are computed combinationally and captured in registers on that edge; `valid_out` marks the cycle in which they are new. Between requests the registered outputs hold their last value.

Top module: `postmod_agen`

## Requirements
- R1: Mode 0 (immediate post-increment): the address is the old base and the written-back base is base plus the immediate, modulo 2^AW; `abs_dst` is 0 in every mode other than 5.
- R2: Mode 1 (modifier post-increment): the address is the old base and the written-back base is base plus the full modifier value.
- R3: Mode 2 (bit-reversed): the address is the old base with its low 16 bits in reversed order (bit i moves to bit 15-i) and bits 31:16 unchanged; the written-back base is base plus the modifier.
- R4: Mode 3 (circular, immediate): the address is the old base; the buffer length is modifier bits 16:0 and starts at `circ_start`; for a non-negative immediate, a sum at or above start plus length has the length subtracted, otherwise the sum is written back.
- R5: In both circular modes a negative increment whose sum falls below `circ_start` has the length added back, so the new base lands the same distance below the buffer end.
- R6: Mode 4 (circular, register): the increment is modifier bits 31:17 as a signed value shifted left by the size code (size 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes), then applied with the circular rules of R4 and R5.
- R7: Mode 5 (absolute set): the address and `abs_dst` both equal the immediate and the written-back base equals the old base.
- R8: Mode codes 6 and 7 are reserved: the address and the written-back base both equal the old base.
- R9: Outputs change only on the clock edge where `valid_in` is high; `valid_out` is high for exactly the following cycle per request, and the outputs hold otherwise.
- R10: While reset is asserted all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe; inputs are sampled on this edge |
| mode | input | 3 | Addressing mode code (0..5, 6/7 reserved) |
| size | input | 2 | Access size as log2 of bytes |
| base | input | AW | Current base register value |
| modifier | input | AW | Modifier register (length in 16:0, increment in 31:17) |
| circ_start | input | AW | Circular buffer start address |
| imm | input | AW | Extended immediate |
| valid_out | output | 1 | Outputs updated in this cycle |
| ea | output | AW | Effective address |
| base_wb | output | AW | Value to write back to the base register |
| abs_dst | output | AW | Absolute-set destination value |

## Verification
A wrong wrap decision in the circular adder shows up in `base_wb` on the cycle after the request, as a value off by exactly one buffer length, so the bench places increments that land just inside, exactly on, and just past each buffer boundary. A misrouted bit in the reversal network or a wrong scale shift shows as a single-bit or power-of-two error in `ea` or `base_wb` in that same cycle. Stale or prematurely updated output registers are seen by changing the inputs without a strobe and checking that nothing moves over two further cycles.

// File: rtl/postmod_agen_pkg.sv
package postmod_agen_pkg;

   // Addressing mode codes presented on the mode port.
   localparam logic [2:0] AM_PI_IMM   = 3'd0;
   localparam logic [2:0] AM_PI_MOD   = 3'd1;
   localparam logic [2:0] AM_BREV     = 3'd2;
   localparam logic [2:0] AM_CIRC_IMM = 3'd3;
   localparam logic [2:0] AM_CIRC_REG = 3'd4;
   localparam logic [2:0] AM_ABS_SET  = 3'd5;

   // Access size codes (log2 of bytes).
   typedef enum logic [1:0] {
      SZ_BYTE   = 2'd0,
      SZ_HALF   = 2'd1,
      SZ_WORD   = 2'd2,
      SZ_DOUBLE = 2'd3
   } agen_size_e;

endpackage

// File: rtl/postmod_agen_brev.sv
// Reverses the low REV_W bits of the input; the bits above pass through.
module postmod_agen_brev #(
   parameter int AW    = 32,
   parameter int REV_W = 16
) (
   input  logic [AW-1:0] din,
   output logic [AW-1:0] dout
);

   if (REV_W < 2 || REV_W > AW) begin : g_bad_rev_w
      $error("postmod_agen_brev: REV_W must lie in 2..AW");
   end

   for (genvar i = 0; i < REV_W; i++) begin : g_rev
      assign dout[i] = din[REV_W-1-i];
   end

   if (REV_W < AW) begin : g_upper
      assign dout[AW-1:REV_W] = din[AW-1:REV_W];
   end

endmodule

// File: rtl/postmod_agen_circ.sv
// Circular-buffer add: sum = base + inc, folded back into [start, start+len).
module postmod_agen_circ #(
   parameter int AW    = 32,
   parameter int LEN_W = 17
) (
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    inc,
   input  logic [AW-1:0]    start,
   input  logic [LEN_W-1:0] len,
   output logic [AW-1:0]    result
);

   localparam int PAD_W = AW - LEN_W;

   if (LEN_W < 1 || LEN_W >= AW) begin : g_bad_len_w
      $error("postmod_agen_circ: LEN_W must lie in 1..AW-1");
   end

   logic [AW-1:0] len_ext;
   logic [AW-1:0] sum;
   logic [AW-1:0] stop;
   logic          inc_neg;

   assign len_ext = {{PAD_W{1'b0}}, len};
   assign sum     = base + inc;
   assign stop    = start + len_ext;
   assign inc_neg = inc[AW-1];

   always_comb begin
      result = sum;
      if (!inc_neg && (sum >= stop)) begin
         result = sum - len_ext;
      end else if (inc_neg && (sum < start)) begin
         result = sum + len_ext;
      end
   end

endmodule

// File: rtl/postmod_agen.sv
module postmod_agen
   import postmod_agen_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 17,
   parameter int REV_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_in,
   input  logic [2:0]    mode,
   input  logic [1:0]    size,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] modifier,
   input  logic [AW-1:0] circ_start,
   input  logic [AW-1:0] imm,
   output logic          valid_out,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] base_wb,
   output logic [AW-1:0] abs_dst
);

   localparam int INC_W = AW - LEN_W;   // width of the register increment field
   localparam int SEXT_W = AW - INC_W;

   if (AW < 8) begin : g_bad_aw
      $error("postmod_agen: AW must be at least 8");
   end
   if (INC_W < 2) begin : g_bad_inc_w
      $error("postmod_agen: LEN_W leaves no increment field");
   end

   // ---------------- increment selection ----------------
   logic [INC_W-1:0] inc_field;
   logic [AW-1:0]    inc_sext;
   logic [AW-1:0]    inc_scaled;
   logic [AW-1:0]    circ_inc;
   logic [AW-1:0]    circ_res;
   logic [AW-1:0]    brev_addr;

   assign inc_field  = modifier[AW-1:LEN_W];
   assign inc_sext   = {{SEXT_W{inc_field[INC_W-1]}}, inc_field};
   assign inc_scaled = inc_sext << size;
   assign circ_inc   = (mode == AM_CIRC_REG) ? inc_scaled : imm;

   postmod_agen_circ #(
      .AW    (AW),
      .LEN_W (LEN_W)
   ) u_circ (
      .base   (base),
      .inc    (circ_inc),
      .start  (circ_start),
      .len    (modifier[LEN_W-1:0]),
      .result (circ_res)
   );

   postmod_agen_brev #(
      .AW    (AW),
      .REV_W (REV_W)
   ) u_brev (
      .din  (base),
      .dout (brev_addr)
   );

   // ---------------- mode mux ----------------
   logic [AW-1:0] ea_n;
   logic [AW-1:0] wb_n;
   logic [AW-1:0] abs_n;

   always_comb begin
      ea_n  = base;
      wb_n  = base;
      abs_n = '0;
      case (mode)
         AM_PI_IMM:   wb_n = base + imm;
         AM_PI_MOD:   wb_n = base + modifier;
         AM_BREV: begin
            ea_n = brev_addr;
            wb_n = base + modifier;
         end
         AM_CIRC_IMM: wb_n = circ_res;
         AM_CIRC_REG: wb_n = circ_res;
         AM_ABS_SET: begin
            ea_n  = imm;
            abs_n = imm;
         end
         default: ;
      endcase
   end

   // ---------------- output registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         ea        <= '0;
         base_wb   <= '0;
         abs_dst   <= '0;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            ea      <= ea_n;
            base_wb <= wb_n;
            abs_dst <= abs_n;
         end
      end
   end

   // ---------------- assertions ----------------
   p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
   p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> ($stable(ea) && $stable(base_wb) && $stable(abs_dst)));
   p_ea_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && (mode == AM_PI_IMM || mode == AM_PI_MOD ||
                    mode == AM_CIRC_IMM || mode == AM_CIRC_REG))
      |=> (ea == $past(base)));
   p_brev_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode == AM_BREV)
      |=> (ea[AW-1:REV_W] == $past(base[AW-1:REV_W])));
   p_abs_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode == AM_ABS_SET)
      |=> (ea == abs_dst && base_wb == $past(base)));
   p_abs_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode != AM_ABS_SET) |=> (abs_dst == '0));

   // Circular immediate result stays inside the buffer when the start point
   // is inside and the step is no longer than the buffer.
   logic [AW-1:0] chk_len;
   logic [AW-1:0] chk_mag;
   logic          chk_in_buf;
   assign chk_len    = {{INC_W{1'b0}}, modifier[LEN_W-1:0]};
   assign chk_mag    = imm[AW-1] ? (~imm + 1'b1) : imm;
   assign chk_in_buf = (base >= circ_start) && (base < circ_start + chk_len) &&
                       (chk_mag <= chk_len) && (circ_start >= chk_len);
   p_circ_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode == AM_CIRC_IMM && chk_in_buf)
      |=> ((base_wb >= $past(circ_start)) &&
           (base_wb < $past(circ_start) + $past(chk_len))));

endmodule

// File: tb/postmod_agen_tb.sv
`timescale 1ns/1ps
module postmod_agen_tb;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic [2:0]    mode = '0;
   logic [1:0]    size = '0;
   logic [AW-1:0] base = '0;
   logic [AW-1:0] modifier = '0;
   logic [AW-1:0] circ_start = '0;
   logic [AW-1:0] imm = '0;
   logic          valid_out;
   logic [AW-1:0] ea;
   logic [AW-1:0] base_wb;
   logic [AW-1:0] abs_dst;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   postmod_agen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_in   (valid_in),
      .mode       (mode),
      .size       (size),
      .base       (base),
      .modifier   (modifier),
      .circ_start (circ_start),
      .imm        (imm),
      .valid_out  (valid_out),
      .ea         (ea),
      .base_wb    (base_wb),
      .abs_dst    (abs_dst)
   );

   task automatic check(input string tag, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Present one request, then check the registered result one cycle later.
   task automatic issue(input logic [2:0] m, input logic [1:0] sz,
                        input logic [AW-1:0] b, input logic [AW-1:0] md,
                        input logic [AW-1:0] cs, input logic [AW-1:0] im);
      @(negedge clk);
      mode = m; size = sz; base = b; modifier = md; circ_start = cs; imm = im;
      valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 valid_out", {31'd0, valid_out}, 32'd0);
      check("R10 ea", ea, 32'd0);
      check("R10 base_wb", base_wb, 32'd0);
      check("R10 abs_dst", abs_dst, 32'd0);
   endtask

   task automatic t_pi_imm();
      issue(3'd0, 2'd2, 32'h0000_1000, 32'h0, 32'h0, 32'hFFFF_FFFC);
      check("R9 valid_out high", {31'd0, valid_out}, 32'd1);
      check("R1 ea", ea, 32'h0000_1000);
      check("R1 wb negative imm", base_wb, 32'h0000_0FFC);
      check("R1 abs_dst zero", abs_dst, 32'h0);
      issue(3'd0, 2'd0, 32'h0000_1000, 32'h0, 32'h0, 32'h8);
      check("R1 wb positive imm", base_wb, 32'h0000_1008);
   endtask

   task automatic t_pi_mod();
      issue(3'd1, 2'd1, 32'h0000_2000, 32'h0000_0030, 32'h0, 32'h99);
      check("R2 ea", ea, 32'h0000_2000);
      check("R2 wb", base_wb, 32'h0000_2030);
   endtask

   task automatic t_brev();
      issue(3'd2, 2'd0, 32'hABCD_0001, 32'h0000_0100, 32'h0, 32'h0);
      check("R3 ea low bit to top", ea, 32'hABCD_8000);
      check("R3 wb", base_wb, 32'hABCD_0101);
      issue(3'd2, 2'd0, 32'h1234_00F0, 32'h0000_0004, 32'h0, 32'h0);
      check("R3 ea nibble", ea, 32'h1234_0F00);
      check("R3 wb 2", base_wb, 32'h1234_00F4);
   endtask

   task automatic t_circ_imm();
      // buffer 0x100..0x13F, length 0x40
      issue(3'd3, 2'd2, 32'h138, 32'h40, 32'h100, 32'h10);
      check("R4 ea", ea, 32'h138);
      check("R4 wrap past end", base_wb, 32'h108);
      issue(3'd3, 2'd2, 32'h120, 32'h40, 32'h100, 32'h8);
      check("R4 no wrap", base_wb, 32'h128);
      issue(3'd3, 2'd2, 32'h13C, 32'h40, 32'h100, 32'h4);
      check("R4 exactly at end", base_wb, 32'h100);
      issue(3'd3, 2'd2, 32'h104, 32'h40, 32'h100, 32'hFFFF_FFF8);
      check("R5 wrap below start", base_wb, 32'h13C);
      issue(3'd3, 2'd2, 32'h108, 32'h40, 32'h100, 32'hFFFF_FFF8);
      check("R5 exactly at start", base_wb, 32'h100);
   endtask

   task automatic t_circ_reg();
      // field 3, word size -> +12
      issue(3'd4, 2'd2, 32'h130, 32'h0006_0040, 32'h100, 32'hDEAD);
      check("R6 ea", ea, 32'h130);
      check("R6 word scale", base_wb, 32'h13C);
      // field -1, double size -> -8
      issue(3'd4, 2'd3, 32'h104, 32'hFFFE_0040, 32'h100, 32'h0);
      check("R6 double negative wrap", base_wb, 32'h13C);
      // field 5, byte size -> +5
      issue(3'd4, 2'd0, 32'h13E, 32'h000A_0040, 32'h100, 32'h0);
      check("R6 byte scale wrap", base_wb, 32'h103);
      // field 5, half size -> +10
      issue(3'd4, 2'd1, 32'h110, 32'h000A_0040, 32'h100, 32'h0);
      check("R6 half scale", base_wb, 32'h11A);
   endtask

   task automatic t_abs();
      issue(3'd5, 2'd2, 32'h0000_0055, 32'h1, 32'h0, 32'hDEAD_0000);
      check("R7 ea", ea, 32'hDEAD_0000);
      check("R7 abs_dst", abs_dst, 32'hDEAD_0000);
      check("R7 wb unchanged", base_wb, 32'h0000_0055);
   endtask

   task automatic t_reserved();
      issue(3'd7, 2'd0, 32'h0000_0777, 32'h10, 32'h0, 32'h5);
      check("R8 ea", ea, 32'h0000_0777);
      check("R8 wb", base_wb, 32'h0000_0777);
      issue(3'd6, 2'd0, 32'h0000_0666, 32'h10, 32'h0, 32'h5);
      check("R8 wb code 6", base_wb, 32'h0000_0666);
   endtask

   task automatic t_hold();
      issue(3'd0, 2'd0, 32'h0000_4000, 32'h0, 32'h0, 32'h4);
      mode = 3'd5; base = 32'hFFFF_0000; imm = 32'h1234_5678;
      @(negedge clk);
      check("R9 valid_out drops", {31'd0, valid_out}, 32'd0);
      @(negedge clk);
      check("R9 ea held", ea, 32'h0000_4000);
      check("R9 wb held", base_wb, 32'h0000_4004);
      check("R9 abs held", abs_dst, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_pi_imm();
      t_pi_mod();
      t_brev();
      t_circ_imm();
      t_circ_reg();
      t_abs();
      t_reserved();
      t_hold();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #50000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule